// File: doc/BRIEF.md
# Management Data Bus Master (Clause-22 Framing)

This block runs read and write transactions on a two-wire PHY management bus. It produces the management clock and controls the bidirectional data line. The tri-state pad is split into three signals: a drive value, a drive enable and a sampled input. A request is a single-cycle pulse. It carries a direction flag, a 5-bit PHY address and a 5-bit register address, plus a 16-bit value when the request is a write. The block then sends one complete frame. When the frame is over it pulses `done` and returns the captured register value, together with an error flag for reads that the PHY did not answer.

The management clock period is fixed by the parameter `MDC_HALF`, which sets the number of system clocks in each half period. The default of 40 gives 2.5 MHz from a 200 MHz system clock. The value must be 2 or more. Each frame opens with a run of ones and then carries the start and opcode symbols. For a read, the master releases the line for the turnaround and checks that the PHY pulls it low. If the PHY does not, the master stops the frame and gives 32 recovery clocks before it reports the error.

Top module: `mdio_master`

## Requirements
- R1: While idle, `busy`, `mdio_oe` and `mdc` are all low. A request is taken only when `req_valid` is high and the block is idle, and `busy` is high in the cycle after that. A `req_valid` pulse during a frame has no effect on that frame and starts no new frame.
- R2: While busy, each low phase and each high phase of `mdc` lasts exactly `MDC_HALF` system clocks.
- R3: A frame begins with 32 `mdc` cycles during which the line is driven to 1.
- R4: After the run of ones, the master drives the start symbol 0 then 1. The opcode follows: 1 then 0 for a read, 0 then 1 for a write.
- R5: The PHY address goes out next and the register address after it, each as 5 bits with the MSB first, one bit per `mdc` cycle.
- R6: The master changes `mdio_o` and `mdio_oe` only while `mdc` is low. The values stay fixed through every high phase, so the PHY samples stable data on the rising edge.
- R7: On a read, the master releases the line for one `mdc` cycle (the turnaround) and samples it while `mdc` is high. If it reads 0, the next 16 cycles are sampled while `mdc` is high and assembled MSB first. The result appears on `rdata` in the `done` cycle and is held until the next frame completes.
- R8: After the 16th read bit, the line stays released for two more `mdc` cycles. A good read therefore has 65 rising edges of `mdc`, and `err` is low.
- R9: On a write, the master drives the turnaround as 1 then 0, then the 16 data bits MSB first. It then releases the line for one last `mdc` cycle, for 65 rising edges in total.
- R10: If the turnaround of a read is sampled as 1, the master keeps the line released for 32 more `mdc` cycles. It then finishes with `err` high in the `done` cycle, for 79 rising edges in total.
- R11: `done` is a single-cycle pulse. `busy` is low in the `done` cycle and high in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Turnaround failure, valid with `done` |
| rdata | output | 16 | Last successfully read value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Line drive value |
| mdio_oe | output | 1 | Line drive enable |
| mdio_i | input | 1 | Sampled line value |

## Verification
Several rules are checked by assertions on every cycle. These cover the quiet idle pads, the start of a frame on an accepted request, edge alignment (drive changes only while `mdc` is low), the line being released during the read turnaround and recovery, and the shape of the `done`/`busy` pulses. Other rules can only be shown by the bench's scenarios, which run a PHY model against the block. These are the bit order of the frame contents, the count of rising edges for each frame kind, the exact half-period length, the captured read value, the error path when the PHY holds back its turnaround zero, and a request arriving mid-frame being ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int unsigned MDIO_DW = 16;
    localparam int unsigned MDIO_AW = 5;
    // start symbol + opcode + two address fields
    localparam int unsigned HDR_W   = 4 + 2 * MDIO_AW;

    localparam logic [1:0] SYM_START = 2'b01;
    localparam logic [1:0] SYM_OP_RD = 2'b10;
    localparam logic [1:0] SYM_OP_WR = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_RDAT,
        ST_WDAT,
        ST_TAIL,
        ST_RECOV
    } phase_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int unsigned HALF = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic slot_end
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_t;

    gen_t gen_d, gen_q;
    logic fall_d;

    always_comb begin
        gen_d  = gen_q;
        fall_d = 1'b0;
        if (!run) begin
            gen_d.cnt = '0;
            gen_d.mdc = 1'b0;
        end else if (gen_q.cnt == CW'(HALF - 1)) begin
            gen_d.cnt = '0;
            gen_d.mdc = ~gen_q.mdc;
            fall_d    = gen_q.mdc;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign mdc      = gen_q.mdc;
    assign slot_end = fall_d;

    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc); // R1
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int unsigned PRE_LEN   = 32,
    parameter int unsigned RECOV_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_read,
    input  logic [MDIO_AW-1:0] req_phy,
    input  logic [MDIO_AW-1:0] req_reg,
    input  logic [MDIO_DW-1:0] req_wdata,
    input  logic               slot_end,
    input  logic               mdio_i,
    output logic               run,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [MDIO_DW-1:0] rdata,
    output logic               mdio_o,
    output logic               mdio_oe
);
    localparam int unsigned MAX_A  = (PRE_LEN > RECOV_LEN) ? PRE_LEN : RECOV_LEN;
    localparam int unsigned MAX_B  = (MDIO_DW > HDR_W) ? MDIO_DW : HDR_W;
    localparam int unsigned MAX_L  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W  = $clog2(MAX_L);

    typedef struct packed {
        phase_e             st;
        logic [CNT_W-1:0]   cnt;
        logic [HDR_W-1:0]   hdr;
        logic [MDIO_DW-1:0] sh;
        logic               rd;
        logic               o;
        logic               oe;
        logic               done;
        logic               err;
        logic [MDIO_DW-1:0] rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st  = ST_PRE;
                    seq_d.cnt = '0;
                    seq_d.hdr = {SYM_START, (req_read ? SYM_OP_RD : SYM_OP_WR),
                                 req_phy, req_reg};
                    seq_d.sh  = req_wdata;
                    seq_d.rd  = req_read;
                    seq_d.o   = 1'b1;
                    seq_d.oe  = 1'b1;
                end
            end
            ST_PRE: begin
                if (slot_end) begin
                    if (seq_q.cnt == CNT_W'(PRE_LEN - 1)) begin
                        seq_d.st  = ST_HDR;
                        seq_d.cnt = '0;
                        seq_d.o   = seq_q.hdr[HDR_W-1];
                        seq_d.hdr = seq_q.hdr << 1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            ST_HDR: begin
                if (slot_end) begin
                    if (seq_q.cnt == CNT_W'(HDR_W - 1)) begin
                        seq_d.st  = ST_TA;
                        seq_d.cnt = '0;
                        if (seq_q.rd) begin
                            seq_d.oe = 1'b0;
                        end else begin
                            seq_d.o = 1'b1;
                        end
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                        seq_d.o   = seq_q.hdr[HDR_W-1];
                        seq_d.hdr = seq_q.hdr << 1;
                    end
                end
            end
            ST_TA: begin
                if (slot_end) begin
                    if (seq_q.rd) begin
                        seq_d.cnt = '0;
                        seq_d.st  = mdio_i ? ST_RECOV : ST_RDAT;
                    end else if (seq_q.cnt == '0) begin
                        seq_d.o   = 1'b0;
                        seq_d.cnt = CNT_W'(1);
                    end else begin
                        seq_d.st  = ST_WDAT;
                        seq_d.cnt = '0;
                        seq_d.o   = seq_q.sh[MDIO_DW-1];
                        seq_d.sh  = seq_q.sh << 1;
                    end
                end
            end
            ST_RDAT: begin
                if (slot_end) begin
                    seq_d.sh = {seq_q.sh[MDIO_DW-2:0], mdio_i};
                    if (seq_q.cnt == CNT_W'(MDIO_DW - 1)) begin
                        seq_d.st  = ST_TAIL;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            ST_WDAT: begin
                if (slot_end) begin
                    if (seq_q.cnt == CNT_W'(MDIO_DW - 1)) begin
                        seq_d.st  = ST_TAIL;
                        seq_d.cnt = '0;
                        seq_d.oe  = 1'b0;
                        seq_d.o   = 1'b0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                        seq_d.o   = seq_q.sh[MDIO_DW-1];
                        seq_d.sh  = seq_q.sh << 1;
                    end
                end
            end
            ST_TAIL: begin
                if (slot_end) begin
                    if (seq_q.cnt == (seq_q.rd ? CNT_W'(1) : CNT_W'(0))) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                        seq_d.o    = 1'b0;
                        if (seq_q.rd) begin
                            seq_d.rdata = seq_q.sh;
                        end
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            ST_RECOV: begin
                if (slot_end) begin
                    if (seq_q.cnt == CNT_W'(RECOV_LEN - 1)) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                        seq_d.err  = 1'b1;
                        seq_d.o    = 1'b0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign run     = (seq_q.st != ST_IDLE);
    assign busy    = run;
    assign done    = seq_q.done;
    assign err     = seq_q.err;
    assign rdata   = seq_q.rdata;
    assign mdio_o  = seq_q.o;
    assign mdio_oe = seq_q.oe;

    AST_TA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_TA && seq_q.rd) |-> !mdio_oe); // R7
    AST_RECOV_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_RECOV) |-> !mdio_oe); // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R11
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int unsigned MDC_HALF  = 40,
    parameter int unsigned PRE_LEN   = 32,
    parameter int unsigned RECOV_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_read,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic run;
    logic slot_end;

    mdio_mdc_gen #(
        .HALF (MDC_HALF)
    ) mdc_gen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mdc      (mdc),
        .slot_end (slot_end)
    );

    mdio_frame_seq #(
        .PRE_LEN   (PRE_LEN),
        .RECOV_LEN (RECOV_LEN)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_read  (req_read),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .slot_end  (slot_end),
        .mdio_i    (mdio_i),
        .run       (run),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rdata     (rdata),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc)); // R1
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R1
    AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc); // R6
    AST_OE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> !mdc); // R6
endmodule

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        mdio_line;
    logic        phy_oe = 1'b0;
    logic        phy_o  = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    mdio_master #(.MDC_HALF(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    // PHY model state
    int          rcnt = 0;
    int          base = 0;
    bit          frm_read = 1'b0;
    bit          frm_hold = 1'b0;
    logic [15:0] frm_pat = '0;
    logic        line_bits [0:127];
    logic        oe_bits   [0:127];

    always @(posedge mdc) begin
        rcnt = rcnt + 1;
        if (rcnt - base < 128) begin
            line_bits[rcnt - base] = mdio_line;
            oe_bits[rcnt - base]   = mdio_oe;
        end
    end

    always @(negedge mdc) begin
        #1;
        if (frm_read && !frm_hold) begin
            if (rcnt - base == 46) begin
                phy_oe = 1'b1;
                phy_o  = 1'b0;
            end else if (rcnt - base >= 47 && rcnt - base <= 62) begin
                phy_o = frm_pat[62 - (rcnt - base)];
            end else if (rcnt - base == 63) begin
                phy_oe = 1'b0;
                phy_o  = 1'b1;
            end
        end
    end

    // Observers away from the active edge
    int   done_cnt = 0;
    int   run_len  = 0;
    int   len_bad  = 0;
    int   hold_bad = 0;
    int   clash    = 0;
    logic mdc_last = 1'b0;
    logic o_last   = 1'b0;
    logic oe_last  = 1'b0;

    always @(negedge clk) begin
        if (done) done_cnt = done_cnt + 1;
        if (mdio_oe && phy_oe) clash = clash + 1;
        if (busy) begin
            if (mdc == mdc_last) run_len = run_len + 1;
            else begin
                if (run_len != H) len_bad = len_bad + 1;
                run_len = 1;
            end
        end else run_len = 0;
        if (mdc && mdc_last && (mdio_o != o_last || mdio_oe != oe_last))
            hold_bad = hold_bad + 1;
        mdc_last = mdc;
        o_last   = mdio_o;
        oe_last  = mdio_oe;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_pat(input logic [4:0] p, input logic [4:0] r);
        return 16'h9C63 ^ {p, r, p, 1'b1};
    endfunction

    function automatic logic [15:0] wr_val(input logic [4:0] p, input logic [4:0] r);
        return 16'h3A17 ^ {r, ~p, r, 1'b0};
    endfunction

    task automatic run_frame(input bit rd, input logic [4:0] p, input logic [4:0] r,
                             input bit hold, input bit inject);
        logic [15:0] w;
        logic [31:0] pre_act;
        logic [3:0]  so_act, so_exp;
        logic [9:0]  ad_act;
        logic [15:0] d_act;
        logic [15:0] got;
        logic        got_err;
        int          d0, edges, oe_rel, oe_exp, tmo;
        w        = wr_val(p, r);
        frm_read = rd;
        frm_hold = hold;
        frm_pat  = rd_pat(p, r);
        base     = rcnt;
        d0       = done_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_phy = p; req_reg = r; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            repeat (20) @(negedge clk);
            req_valid = 1'b1; req_read = ~rd; req_phy = ~p; req_reg = ~r; req_wdata = ~w;
            @(negedge clk);
            req_valid = 1'b0;
        end
        tmo = 0;
        while (!done && tmo < 5000) begin
            @(negedge clk);
            tmo++;
        end
        chk(done, "R11", "done seen", {31'b0, done}, 32'd1);
        got     = rdata;
        got_err = err;
        chk(!busy, "R11", "busy low in done cycle", {31'b0, busy}, 32'd0);
        edges = rcnt - base;
        for (int i = 0; i < 32; i++) pre_act[31 - i] = line_bits[1 + i];
        chk(pre_act == 32'hFFFF_FFFF, "R3", "preamble", pre_act, 32'hFFFF_FFFF);
        for (int i = 0; i < 4; i++) so_act[3 - i] = line_bits[33 + i];
        so_exp = rd ? 4'b0110 : 4'b0101;
        chk(so_act == so_exp, "R4", "start+opcode", {28'b0, so_act}, {28'b0, so_exp});
        for (int i = 0; i < 10; i++) ad_act[9 - i] = line_bits[37 + i];
        chk(ad_act == {p, r}, "R5", "phy+reg address", {22'b0, ad_act}, {22'b0, p, r});
        oe_rel = 0;
        for (int i = 47; i <= edges && i < 128; i++) if (!oe_bits[i]) oe_rel++;
        if (rd && hold) begin
            chk(got_err, "R10", "err flag", {31'b0, got_err}, 32'd1);
            chk(edges == 79, "R10", "mdc rising edges", edges, 32'd79);
            chk(oe_rel == 33, "R10", "released slots after header", oe_rel, 32'd33);
        end else if (rd) begin
            chk(!got_err, "R8", "err flag", {31'b0, got_err}, 32'd0);
            chk(got == frm_pat, "R7", "read data", {16'b0, got}, {16'b0, frm_pat});
            chk(edges == 65, "R8", "mdc rising edges", edges, 32'd65);
            chk(oe_rel == 19, "R8", "released slots after header", oe_rel, 32'd19);
        end else begin
            for (int i = 0; i < 16; i++) d_act[15 - i] = line_bits[49 + i];
            chk({line_bits[47], line_bits[48]} == 2'b10, "R9", "write turnaround",
                {30'b0, line_bits[47], line_bits[48]}, 32'd2);
            chk(d_act == w, "R9", "write data", {16'b0, d_act}, {16'b0, w});
            chk(edges == 65, "R9", "mdc rising edges", edges, 32'd65);
            oe_exp = 1;
            chk(oe_rel == oe_exp, "R9", "released slots after header", oe_rel, oe_exp);
            chk(!got_err, "R9", "err flag", {31'b0, got_err}, 32'd0);
        end
        repeat (4) @(negedge clk);
        chk(done_cnt == d0 + 1, "R11", "exactly one done per frame", done_cnt - d0, 32'd1);
        if (inject) begin
            chk(!busy && !mdio_oe && !mdc, "R1", "mid-frame request ignored, idle after",
                {29'b0, busy, mdio_oe, mdc}, 32'd0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mdio_oe && !mdc && !done, "R1", "reset idle outputs",
            {28'b0, busy, mdio_oe, mdc, done}, 32'd0);
        repeat (3) @(negedge clk);
        chk(!busy && !mdio_oe && !mdc, "R1", "still idle without request",
            {29'b0, busy, mdio_oe, mdc}, 32'd0);

        for (int p = 0; p < 32; p++) begin
            run_frame(1'b1, 5'(p), 5'(31 - p), 1'b0, 1'b0);
            run_frame(1'b0, 5'(p), 5'(31 - p), 1'b0, 1'b0);
        end
        for (int r = 0; r < 32; r++) begin
            run_frame(1'b1, 5'h11, 5'(r), 1'b0, 1'b0);
            run_frame(1'b0, 5'h0A, 5'(r), 1'b0, 1'b0);
        end
        // turnaround withheld, then normal read recovers
        run_frame(1'b1, 5'h00, 5'h1F, 1'b1, 1'b0);
        run_frame(1'b1, 5'h1F, 5'h00, 1'b1, 1'b0);
        run_frame(1'b1, 5'h03, 5'h04, 1'b0, 1'b0);
        // rdata held across write and error frames (R7)
        run_frame(1'b0, 5'h07, 5'h09, 1'b0, 1'b0);
        chk(rdata == rd_pat(5'h03, 5'h04), "R7", "rdata held after write",
            {16'b0, rdata}, {16'b0, rd_pat(5'h03, 5'h04)});
        // requests during a frame are ignored (R1)
        run_frame(1'b1, 5'h15, 5'h0C, 1'b0, 1'b1);
        run_frame(1'b0, 5'h0B, 5'h1A, 1'b0, 1'b1);

        chk(len_bad == 0, "R2", "mdc half-period length mismatches", len_bad, 32'd0);
        chk(hold_bad == 0, "R6", "drive changes while mdc high", hold_bad, 32'd0);
        chk(clash == 0, "R7", "line driven by both ends", clash, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule